// File: doc/BRIEF.md
# SD Host Interrupt Status Register Block

This block keeps the two interrupt status words of an SD/MMC host controller and the two mask words that gate them onto a single interrupt line. The command engine, the data engine, the block-buffer logic and the card-detect pin feed it. Each reports as a plain input: a one-cycle pulse for an event, or a level for a buffer state. Software reads and writes the four words over a simple 32-bit register port. The port has a write strobe, an address and write data, and it returns read data combinationally for the address presented.

Each status word mixes two kinds of bit. Sticky bits latch an event until software clears them. Live bits show a signal as it is now and cannot be written. These are the synchronized card-detect level, the DAT0 line and the command-busy flag. Software clears sticky bits by writing zeros. The read-buffer and write-buffer ready bits latch on the rising edge of the buffer's level, so they set once per block. The card inserted and removed bits latch on the edges of the synchronized card-detect signal. The interrupt line is raised whenever an unmasked sticky bit is set.

Top module: `sdh_irq_status`

## Requirements
- R1: After reset, every sticky bit in both status words is 0, both mask words read 0xFFFFFFFF, and `irq` is low.
- R2: A pulse on `ev_resp_done` sets status word 1 (offset 0x038) bit 0, and a pulse on `ev_data_done` sets bit 2. Each bit is visible from the cycle after the pulse and stays set until software clears it.
- R3: In status word 2 (offset 0x03C), error pulses set sticky bits: command index bit 0, CRC bit 1, end bit bit 2, data timeout bit 3, illegal write bit 4, illegal read bit 5, response timeout bit 6, illegal access bit 15. Several pulses in one cycle set all of their bits.
- R4: Live bits follow their inputs and ignore writes. Status word 1 bit 5 shows `card_detect` two clock edges after it changes. Status word 2 bit 7 shows `dat0_line` and bit 14 shows `cmd_busy` in the same cycle.
- R5: A write to a status word clears each sticky bit whose write-data bit is 0 and leaves unchanged each sticky bit whose write-data bit is 1.
- R6: When an event sets a sticky bit in the same cycle that a write clears it, the bit ends up set.
- R7: Status word 2 bit 8 sets on a rising edge of `rbuf_full`, and bit 9 sets on a rising edge of `wbuf_empty`. Once cleared, the bit stays clear while the level stays high and sets again only on the next rising edge.
- R8: Status word 1 bit 4 (inserted) sets when the synchronized card-detect level rises, and bit 3 (removed) sets when it falls. Each sets one edge after the live bit changes.
- R9: Mask word 1 (offset 0x040) and mask word 2 (offset 0x044) are full 32-bit registers that read back the last value written.
- R10: `irq` is high exactly when some sticky bit is 1 and its mask bit is 0. Live bits never raise `irq`, whatever their mask bits are.
- R11: Reads of any other address return 0, and writes to any other address change no status or mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ev_resp_done | input | 1 | Response complete pulse |
| ev_data_done | input | 1 | Data transfer complete pulse |
| ev_cmd_idx_err | input | 1 | Command index error pulse |
| ev_crc_err | input | 1 | CRC error pulse |
| ev_end_bit_err | input | 1 | End bit error pulse |
| ev_data_tmo | input | 1 | Data timeout pulse |
| ev_ill_wr | input | 1 | Illegal write pulse |
| ev_ill_rd | input | 1 | Illegal read pulse |
| ev_resp_tmo | input | 1 | Response timeout pulse |
| ev_ill_access | input | 1 | Illegal access pulse |
| rbuf_full | input | 1 | Read buffer holds a full block (level) |
| wbuf_empty | input | 1 | Write buffer can take a block (level) |
| cmd_busy | input | 1 | Command engine busy (level) |
| dat0_line | input | 1 | DAT0 line state (level) |
| card_detect | input | 1 | Raw, asynchronous card-detect pin |
| irq | output | 1 | Interrupt request |

## Verification
A sticky bit that is lost, or set at the wrong position, shows in the read data at the next read of that word. Because `irq` is decoded from state with no extra register, a wrong bit also shows on `irq` in the cycle right after the bad update whenever its mask bit is 0. The bench checks the edge-triggered paths at exact cycles. The live card-detect bit must lag the pin by two edges and the inserted and removed bits by three. A buffer bit must not come back while its level stays high, so a level-triggered or badly synchronized design shows up within a cycle. A bench read one cycle after a same-cycle write and event shows which of the two won.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;

    localparam int DW = 32;

    // register byte offsets
    localparam int OFS_STAT1 = 'h038;
    localparam int OFS_STAT2 = 'h03C;
    localparam int OFS_MASK1 = 'h040;
    localparam int OFS_MASK2 = 'h044;

    // status word 1 bit positions
    localparam int B1_RESP     = 0;
    localparam int B1_DATA     = 2;
    localparam int B1_CARD_OUT = 3;
    localparam int B1_CARD_IN  = 4;
    localparam int B1_CD_LVL   = 5;

    // status word 2 bit positions
    localparam int B2_CMD_IDX  = 0;
    localparam int B2_CRC      = 1;
    localparam int B2_END_BIT  = 2;
    localparam int B2_DATA_TMO = 3;
    localparam int B2_ILL_WR   = 4;
    localparam int B2_ILL_RD   = 5;
    localparam int B2_RESP_TMO = 6;
    localparam int B2_DAT0     = 7;
    localparam int B2_RBUF     = 8;
    localparam int B2_WBUF     = 9;
    localparam int B2_BUSY     = 14;
    localparam int B2_ILL_ACC  = 15;

    localparam logic [DW-1:0] STICKY1 = DW'((1 << B1_RESP) | (1 << B1_DATA) |
                                            (1 << B1_CARD_OUT) | (1 << B1_CARD_IN));
    localparam logic [DW-1:0] STICKY2 = DW'(32'h7F | (1 << B2_RBUF) |
                                            (1 << B2_WBUF) | (1 << B2_ILL_ACC));

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STAT1,
        SEL_STAT2,
        SEL_MASK1,
        SEL_MASK2
    } reg_sel_e;

    typedef struct packed {
        logic resp_done;
        logic data_done;
        logic card_out;
        logic card_in;
    } ev1_t;

    typedef struct packed {
        logic ill_access;
        logic wbuf;
        logic rbuf;
        logic resp_tmo;
        logic ill_rd;
        logic ill_wr;
        logic data_tmo;
        logic end_bit;
        logic crc;
        logic cmd_idx;
    } ev2_t;

    typedef struct packed {
        logic card_lvl;
        logic dat0;
        logic busy;
    } live_t;

    function automatic reg_sel_e decode_addr(input logic [31:0] a);
        case (a)
            32'(OFS_STAT1): return SEL_STAT1;
            32'(OFS_STAT2): return SEL_STAT2;
            32'(OFS_MASK1): return SEL_MASK1;
            32'(OFS_MASK2): return SEL_MASK2;
            default:        return SEL_NONE;
        endcase
    endfunction

    function automatic logic [DW-1:0] place_ev1(input ev1_t e);
        logic [DW-1:0] v;
        v = '0;
        v[B1_RESP]     = e.resp_done;
        v[B1_DATA]     = e.data_done;
        v[B1_CARD_OUT] = e.card_out;
        v[B1_CARD_IN]  = e.card_in;
        return v;
    endfunction

    function automatic logic [DW-1:0] place_ev2(input ev2_t e);
        logic [DW-1:0] v;
        v = '0;
        v[B2_CMD_IDX]  = e.cmd_idx;
        v[B2_CRC]      = e.crc;
        v[B2_END_BIT]  = e.end_bit;
        v[B2_DATA_TMO] = e.data_tmo;
        v[B2_ILL_WR]   = e.ill_wr;
        v[B2_ILL_RD]   = e.ill_rd;
        v[B2_RESP_TMO] = e.resp_tmo;
        v[B2_RBUF]     = e.rbuf;
        v[B2_WBUF]     = e.wbuf;
        v[B2_ILL_ACC]  = e.ill_access;
        return v;
    endfunction

    function automatic logic [DW-1:0] place_live1(input live_t l);
        logic [DW-1:0] v;
        v = '0;
        v[B1_CD_LVL] = l.card_lvl;
        return v;
    endfunction

    function automatic logic [DW-1:0] place_live2(input live_t l);
        logic [DW-1:0] v;
        v = '0;
        v[B2_DAT0] = l.dat0;
        v[B2_BUSY] = l.busy;
        return v;
    endfunction

endpackage

// File: rtl/sdh_cd_sync.sv
module sdh_cd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], raw};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level = chain_q[STAGES-1];
    assign rise  = level & ~prev_q;
    assign fall  = ~level & prev_q;
endmodule

// File: rtl/sdh_edge_rise.sv
module sdh_edge_rise #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/sdh_sticky_bank.sv
module sdh_sticky_bank #(
    parameter int           W         = 32,
    parameter logic [W-1:0] KEEP_BITS = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_clr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] set,
    output logic [W-1:0] q
);
    logic [W-1:0] kept;

    // write-zero clears; an event in the same cycle overrides the clear
    assign kept = wr_clr ? (q & wdata) : q;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= kept | (set & KEEP_BITS);
    end
endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status
    import sdh_irq_pkg::*;
#(
    parameter int AW        = 12,
    parameter int CD_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr_en,
    input  logic [AW-1:0] reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          ev_resp_done,
    input  logic          ev_data_done,
    input  logic          ev_cmd_idx_err,
    input  logic          ev_crc_err,
    input  logic          ev_end_bit_err,
    input  logic          ev_data_tmo,
    input  logic          ev_ill_wr,
    input  logic          ev_ill_rd,
    input  logic          ev_resp_tmo,
    input  logic          ev_ill_access,
    input  logic          rbuf_full,
    input  logic          wbuf_empty,
    input  logic          cmd_busy,
    input  logic          dat0_line,
    input  logic          card_detect,
    output logic          irq
);
    localparam int NWORD = 2;
    localparam logic [NWORD-1:0][DW-1:0] STICKY_TBL = {STICKY2, STICKY1};

    reg_sel_e sel;
    assign sel = decode_addr(32'(reg_addr));

    // card detect synchronizer and edge events
    logic cd_lvl, cd_rise, cd_fall;
    sdh_cd_sync #(.STAGES(CD_STAGES)) u_cd (
        .clk(clk), .rst(rst), .raw(card_detect),
        .level(cd_lvl), .rise(cd_rise), .fall(cd_fall)
    );

    // buffer-ready levels become one pulse per block
    logic [1:0] buf_rise;
    sdh_edge_rise #(.W(2)) u_buf (
        .clk(clk), .rst(rst),
        .lvl({wbuf_empty, rbuf_full}), .rise(buf_rise)
    );

    ev1_t  ev1;
    ev2_t  ev2;
    live_t live;

    always_comb begin
        ev1.resp_done  = ev_resp_done;
        ev1.data_done  = ev_data_done;
        ev1.card_out   = cd_fall;
        ev1.card_in    = cd_rise;
        ev2.ill_access = ev_ill_access;
        ev2.wbuf       = buf_rise[1];
        ev2.rbuf       = buf_rise[0];
        ev2.resp_tmo   = ev_resp_tmo;
        ev2.ill_rd     = ev_ill_rd;
        ev2.ill_wr     = ev_ill_wr;
        ev2.data_tmo   = ev_data_tmo;
        ev2.end_bit    = ev_end_bit_err;
        ev2.crc        = ev_crc_err;
        ev2.cmd_idx    = ev_cmd_idx_err;
        live.card_lvl  = cd_lvl;
        live.dat0      = dat0_line;
        live.busy      = cmd_busy;
    end

    logic [NWORD-1:0][DW-1:0] set_vec;
    logic [NWORD-1:0][DW-1:0] st_q;
    logic [NWORD-1:0][DW-1:0] msk_q;
    logic [NWORD-1:0]         stat_hit;
    logic [NWORD-1:0]         mask_hit;

    assign set_vec[0]  = place_ev1(ev1);
    assign set_vec[1]  = place_ev2(ev2);
    assign stat_hit[0] = reg_wr_en && (sel == SEL_STAT1);
    assign stat_hit[1] = reg_wr_en && (sel == SEL_STAT2);
    assign mask_hit[0] = reg_wr_en && (sel == SEL_MASK1);
    assign mask_hit[1] = reg_wr_en && (sel == SEL_MASK2);

    for (genvar g = 0; g < NWORD; g++) begin : g_word
        sdh_sticky_bank #(.W(DW), .KEEP_BITS(STICKY_TBL[g])) u_bank (
            .clk(clk), .rst(rst), .wr_clr(stat_hit[g]),
            .wdata(reg_wdata), .set(set_vec[g]), .q(st_q[g])
        );

        always_ff @(posedge clk) begin
            if (rst)              msk_q[g] <= '1;
            else if (mask_hit[g]) msk_q[g] <= reg_wdata;
        end
    end

    // named views for the bound checker
    logic [DW-1:0] st1_q, st2_q, msk1_q, msk2_q;
    assign st1_q  = st_q[0];
    assign st2_q  = st_q[1];
    assign msk1_q = msk_q[0];
    assign msk2_q = msk_q[1];

    always_comb begin
        case (sel)
            SEL_STAT1: reg_rdata = st_q[0] | place_live1(live);
            SEL_STAT2: reg_rdata = st_q[1] | place_live2(live);
            SEL_MASK1: reg_rdata = msk_q[0];
            SEL_MASK2: reg_rdata = msk_q[1];
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = |(st_q[0] & ~msk_q[0]) | |(st_q[1] & ~msk_q[1]);
endmodule

// File: rtl/sdh_irq_status_chk.sv
module sdh_irq_status_chk
    import sdh_irq_pkg::*;
#(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_wr_en,
    input logic [AW-1:0] reg_addr,
    input logic [31:0]   reg_wdata,
    input logic [31:0]   reg_rdata,
    input logic          dat0_line,
    input logic          cmd_busy,
    input logic          irq,
    input logic [DW-1:0] st1_q,
    input logic [DW-1:0] st2_q,
    input logic [DW-1:0] msk1_q,
    input logic [DW-1:0] msk2_q
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (st1_q == '0 && st2_q == '0 && &msk1_q && &msk2_q));

    assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr_en && reg_addr == AW'(OFS_STAT1))
        |=> ((st1_q & $past(st1_q)) == $past(st1_q)));

    assert_live_bits_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == AW'(OFS_STAT2))
        |-> (reg_rdata[B2_DAT0] == dat0_line && reg_rdata[B2_BUSY] == cmd_busy));

    assert_write_one_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == AW'(OFS_STAT2))
        |=> ((st2_q & $past(reg_wdata & st2_q)) == $past(reg_wdata & st2_q)));

    assert_mask_load_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == AW'(OFS_MASK1)) |=> (msk1_q == $past(reg_wdata)));

    assert_all_masked_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (&msk1_q && &msk2_q) |-> !irq);
endmodule

bind sdh_irq_status sdh_irq_status_chk #(.AW(AW)) chk_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dat0_line(dat0_line),
    .cmd_busy(cmd_busy), .irq(irq), .st1_q(st1_q), .st2_q(st2_q),
    .msk1_q(msk1_q), .msk2_q(msk2_q)
);

// File: tb/sdh_irq_status_tb.sv
`timescale 1ns/1ps
module sdh_irq_status_tb_top;
    import sdh_irq_pkg::*;

    localparam int AW = 12;
    localparam logic [AW-1:0] A_ST1 = AW'(OFS_STAT1);
    localparam logic [AW-1:0] A_ST2 = AW'(OFS_STAT2);
    localparam logic [AW-1:0] A_M1  = AW'(OFS_MASK1);
    localparam logic [AW-1:0] A_M2  = AW'(OFS_MASK2);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr_en = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [9:0]    ev = '0;
    logic          rbuf_full = 1'b0, wbuf_empty = 1'b0;
    logic          cmd_busy = 1'b0, dat0_line = 1'b0, card_detect = 1'b0;
    logic          irq;

    always #2 clk = ~clk;

    sdh_irq_status #(.AW(AW)) dut_i (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_resp_done(ev[0]), .ev_data_done(ev[1]), .ev_cmd_idx_err(ev[2]),
        .ev_crc_err(ev[3]), .ev_end_bit_err(ev[4]), .ev_data_tmo(ev[5]),
        .ev_ill_wr(ev[6]), .ev_ill_rd(ev[7]), .ev_resp_tmo(ev[8]),
        .ev_ill_access(ev[9]), .rbuf_full(rbuf_full), .wbuf_empty(wbuf_empty),
        .cmd_busy(cmd_busy), .dat0_line(dat0_line), .card_detect(card_detect),
        .irq(irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // monitor: compares queued expectations just after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_item_t it;
                logic [31:0] got;
                it  = exp_q.pop_front();
                got = it.is_irq ? {31'b0, irq} : reg_rdata;
                n_chk++;
                if (got !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, got, it.exp);
                end
            end
        end
    end

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        exp_item_t it;
        @(negedge clk);
        reg_addr = a;
        it.is_irq = 0; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic chk_irq(input bit e, input string tag);
        exp_item_t it;
        @(negedge clk);
        it.is_irq = 1; it.exp = {31'b0, e}; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [9:0] v);
        @(negedge clk);
        ev = v;
        @(negedge clk);
        ev = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_ST1, 32'h0, "R1 status1 after reset");
        rd(A_ST2, 32'h0, "R1 status2 after reset");
        rd(A_M1, 32'hFFFF_FFFF, "R1 mask1 after reset");
        rd(A_M2, 32'hFFFF_FFFF, "R1 mask2 after reset");
        chk_irq(1'b0, "R1 irq after reset");

        // R2 word 1 events
        pulse(10'h001);
        rd(A_ST1, 32'h1, "R2 response done bit0");
        pulse(10'h002);
        rd(A_ST1, 32'h5, "R2 data done bit2");
        rd(A_ST1, 32'h5, "R2 bits hold");

        // R5 selective clear
        wr(A_ST1, 32'hFFFF_FFFE);
        rd(A_ST1, 32'h4, "R5 clear bit0 keep bit2");
        wr(A_ST1, 32'h0);
        rd(A_ST1, 32'h0, "R5 write zero clears all");

        // R3 error mapping
        pulse(10'h108);
        rd(A_ST2, 32'h42, "R3 crc bit1 and response timeout bit6");
        pulse(10'h200);
        rd(A_ST2, 32'h8042, "R3 illegal access bit15");
        pulse(10'h0F4);
        rd(A_ST2, 32'h807F, "R3 idx end dtmo illwr illrd bits");
        wr(A_ST2, 32'h0);
        rd(A_ST2, 32'h0, "R5 status2 cleared");

        // R4 live levels ignore writes
        @(negedge clk);
        dat0_line = 1'b1; cmd_busy = 1'b1;
        rd(A_ST2, 32'h4080, "R4 dat0 bit7 busy bit14");
        wr(A_ST2, 32'h0);
        rd(A_ST2, 32'h4080, "R4 live bits ignore write");
        @(negedge clk);
        dat0_line = 1'b0; cmd_busy = 1'b0;
        rd(A_ST2, 32'h0, "R4 live bits follow low");

        // R6 set beats clear
        pulse(10'h002);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = A_ST1; reg_wdata = 32'h0; ev = 10'h001;
        @(negedge clk);
        reg_wr_en = 1'b0; ev = '0;
        rd(A_ST1, 32'h1, "R6 set wins over same-cycle clear");
        wr(A_ST1, 32'h0);

        // R7 buffer edges
        @(negedge clk);
        rbuf_full = 1'b1;
        rd(A_ST2, 32'h100, "R7 read buffer ready on rise");
        wr(A_ST2, 32'h0);
        rd(A_ST2, 32'h0, "R7 stays clear while level high");
        rd(A_ST2, 32'h0, "R7 still clear");
        @(negedge clk);
        rbuf_full = 1'b0;
        @(negedge clk);
        rbuf_full = 1'b1;
        rd(A_ST2, 32'h100, "R7 sets again on next rise");
        @(negedge clk);
        wbuf_empty = 1'b1;
        rd(A_ST2, 32'h300, "R7 write buffer ready bit9");
        @(negedge clk);
        rbuf_full = 1'b0; wbuf_empty = 1'b0;
        wr(A_ST2, 32'h0);

        // R8 / R4 card detect timing
        @(negedge clk);
        card_detect = 1'b1;
        rd(A_ST1, 32'h00, "R4 live card level not yet after one edge");
        rd(A_ST1, 32'h20, "R4 live card level after two edges");
        rd(A_ST1, 32'h30, "R8 inserted bit4");
        wr(A_ST1, 32'h0);
        rd(A_ST1, 32'h20, "R8 inserted cleared live stays");
        @(negedge clk);
        card_detect = 1'b0;
        rd(A_ST1, 32'h20, "R4 live card level holds one edge");
        rd(A_ST1, 32'h00, "R4 live card level drops");
        rd(A_ST1, 32'h08, "R8 removed bit3");

        // R9 / R10 masks and interrupt
        wr(A_M1, 32'hFFFF_FFFE);
        rd(A_M1, 32'hFFFF_FFFE, "R9 mask1 readback");
        chk_irq(1'b0, "R10 masked removed bit no irq");
        pulse(10'h001);
        chk_irq(1'b1, "R10 unmasked response raises irq");
        rd(A_ST1, 32'h09, "R2 response and removed set");
        wr(A_ST1, 32'h0);
        chk_irq(1'b0, "R10 irq drops after clear");
        wr(A_M1, 32'hFFFF_FFFF);
        wr(A_M2, 32'hFFFF_7FFF);
        rd(A_M2, 32'hFFFF_7FFF, "R9 mask2 readback");
        pulse(10'h200);
        chk_irq(1'b1, "R10 illegal access raises irq");
        wr(A_M2, 32'hFFFF_FFFF);
        chk_irq(1'b0, "R10 remasked no irq");
        wr(A_M2, 32'hFFFF_FF7F);
        @(negedge clk);
        dat0_line = 1'b1;
        chk_irq(1'b0, "R10 live dat0 never raises irq");
        rd(A_ST2, 32'h8080, "R10 status2 content");

        // R11 unmapped addresses
        rd(12'h000, 32'h0, "R11 unmapped read zero");
        wr(12'h048, 32'h0);
        rd(A_ST2, 32'h8080, "R11 unmapped write no effect");
        rd(A_M2, 32'hFFFF_FF7F, "R11 mask untouched");
        rd(12'h048, 32'h0, "R11 unmapped read after write");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule